// File: doc/BRIEF.md
# Network-Coded Symbol Selective Decision Unit

This block sits behind the linear detector of a two-way relay. For each received vector, the detector gives four real fixed-point estimates. Two of them are sums of the two users' BPSK symbols, one per spatial stream. The other two are differences of those symbols, in the same stream order. The block turns this vector into two network-coded symbols, each +1 or -1, so that the relay can re-broadcast the exclusive-or of the two users' bits without ever separating them.

Both the sum and the difference estimate of a stream carry the coded bit. The block trusts whichever of the two is less noisy. The noise gain of a detector output is the energy of the matching row of the combining weight matrix, so the block takes the complex rows of that matrix and compares the gain of the sum output with that of its companion difference output, two places further on. If the sum is quieter, a large sum magnitude means the users agreed (+1). Otherwise, a small difference magnitude means the same. The magnitude test uses a programmable threshold. The unit accepts one vector per clock and returns its result a fixed three cycles later, with a matching valid strobe.

Top module: `pnc_sel_decide`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid` is 0 and `sym` is 2'b00.
- R2: Lane j of `det_y` is bits [j*DW +: DW], as two's complement. Lanes 0 and 1 are the sum estimates of streams 1 and 2, and lanes 2 and 3 are the difference estimates of streams 1 and 2. Weight element (row r, column c) is bits [(r*NCOL+c)*GW +: GW] of `g_re` and `g_im`, as two's complement.
- R3: For pair p (0 or 1), if the energy of row p (the sum over its columns of re²+im²) is strictly less than the energy of row p+2, then `sym[p]` is 0 when |lane p| ≥ `gamma` and 1 otherwise.
- R4: Otherwise, including when the two energies are equal, `sym[p]` is 0 when `gamma` ≥ |lane p+2| and 1 otherwise.
- R5: A comparison whose sign argument is exactly zero (magnitude equal to `gamma`) gives 0, which encodes +1. 1 encodes -1.
- R6: `out_valid` equals `in_valid` delayed by exactly three clock cycles, and back-to-back vectors are accepted every cycle.
- R7: In a cycle where `out_valid` is 0, `sym` keeps the value of the last valid result, whatever the inputs do.
- R8: `sym[0]` depends only on rows 0 and 2 and on lanes 0 and 2. `sym[1]` depends only on rows 1 and 3 and on lanes 1 and 3.
- R9: The most negative lane value, -2^(DW-1), is treated as the magnitude 2^(DW-1). `gamma` is unsigned.
- R10: Row energies are exact even when every weight element is at negative full scale, so a full-scale row compares correctly against a slightly smaller one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a valid input vector |
| det_y | input | 4*DW | Four detector estimates, in the lane order given in R2 |
| g_re | input | 4*NCOL*GW | Real parts of the combining weight rows |
| g_im | input | 4*NCOL*GW | Imaginary parts of the combining weight rows |
| gamma | input | DW | Unsigned decision threshold |
| out_valid | output | 1 | Marks a valid `sym` |
| sym | output | 2 | Coded symbols, bit p for stream p+1 (0 = +1, 1 = -1) |

## Verification
Random weight rows and estimates drive both branches for both streams in long back-to-back and gapped runs. The gapped runs show whether the valid delay and the hold of `sym` between results are right. Directed vectors place a magnitude exactly on the threshold in each branch, tie the two row energies, and feed the most negative lane value. These separate a strict from a non-strict compare and a wrong tie-break. A pair of near-full-scale rows whose energies differ by one element exposes any energy accumulator that is too narrow. Vectors in which the two streams take opposite branches catch crossed row or lane wiring.

// File: rtl/pnc_sel_pkg.sv
package pnc_sel_pkg;
    localparam int  N_LANE    = 4;
    localparam int  N_PAIR    = 2;
    localparam int  PIPE_LAT  = 3;
    localparam logic SYM_PLUS  = 1'b0;
    localparam logic SYM_MINUS = 1'b1;
endpackage

// File: rtl/pnc_row_energy.sv
module pnc_row_energy #(
    parameter int GW   = 10,
    parameter int NCOL = 4,
    parameter int EW   = 2 * GW + $clog2(2 * NCOL)
) (
    input  logic [NCOL*GW-1:0] re_row,
    input  logic [NCOL*GW-1:0] im_row,
    output logic [EW-1:0]      energy
);
    localparam int PW = 2 * GW;

    always_comb begin
        logic signed [GW-1:0] a;
        logic signed [GW-1:0] b;
        logic signed [PW-1:0] sa;
        logic signed [PW-1:0] sb;
        energy = '0;
        for (int c = 0; c < NCOL; c++) begin
            a = re_row[c*GW +: GW];
            b = im_row[c*GW +: GW];
            sa = a * a;
            sb = b * b;
            energy = energy + EW'($unsigned(sa)) + EW'($unsigned(sb));
        end
    end
endmodule

// File: rtl/pnc_mag.sv
module pnc_mag #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] val,
    output logic [DW-1:0] mag
);
    always_comb begin
        mag = val[DW-1] ? (~val + 1'b1) : val;
    end
endmodule

// File: rtl/pnc_pair_pick.sv
module pnc_pair_pick
    import pnc_sel_pkg::*;
#(
    parameter int DW = 12,
    parameter int EW = 23
) (
    input  logic [EW-1:0] e_own,
    input  logic [EW-1:0] e_peer,
    input  logic [DW-1:0] m_sum,
    input  logic [DW-1:0] m_diff,
    input  logic [DW-1:0] thr,
    output logic          use_sum,
    output logic          bit_sum,
    output logic          bit_diff
);
    always_comb begin
        use_sum  = (e_own < e_peer);
        bit_sum  = (m_sum >= thr) ? SYM_PLUS : SYM_MINUS;
        bit_diff = (thr >= m_diff) ? SYM_PLUS : SYM_MINUS;
    end
endmodule

// File: rtl/pnc_sel_decide.sv
module pnc_sel_decide
    import pnc_sel_pkg::*;
#(
    parameter int DW   = 12,
    parameter int GW   = 10,
    parameter int NCOL = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [N_LANE*DW-1:0]      det_y,
    input  logic [N_LANE*NCOL*GW-1:0] g_re,
    input  logic [N_LANE*NCOL*GW-1:0] g_im,
    input  logic [DW-1:0]             gamma,
    output logic                      out_valid,
    output logic [N_PAIR-1:0]         sym
);
    localparam int EW   = 2 * GW + $clog2(2 * NCOL);
    localparam int ROWW = NCOL * GW;

    typedef struct packed {
        logic                          vld;
        logic [DW-1:0]                 gam;
        logic [N_LANE-1:0][EW-1:0]     en;
        logic [N_LANE-1:0][DW-1:0]     mag;
    } st1_t;

    typedef struct packed {
        logic                          vld;
        logic [N_PAIR-1:0]             use_sum;
        logic [N_PAIR-1:0]             b_sum;
        logic [N_PAIR-1:0]             b_diff;
    } st2_t;

    typedef struct packed {
        logic                          vld;
        logic [N_PAIR-1:0]             sym;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [EW-1:0]     en_w   [N_LANE];
    logic [DW-1:0]     mag_w  [N_LANE];
    logic [N_PAIR-1:0] use_w;
    logic [N_PAIR-1:0] bsum_w;
    logic [N_PAIR-1:0] bdiff_w;

    for (genvar r = 0; r < N_LANE; r++) begin : g_lane
        pnc_row_energy #(.GW(GW), .NCOL(NCOL), .EW(EW)) row_i (
            .re_row (g_re[r*ROWW +: ROWW]),
            .im_row (g_im[r*ROWW +: ROWW]),
            .energy (en_w[r])
        );
        pnc_mag #(.DW(DW)) mag_i (
            .val (det_y[r*DW +: DW]),
            .mag (mag_w[r])
        );
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        pnc_pair_pick #(.DW(DW), .EW(EW)) pick_i (
            .e_own    (pipe_q.s1.en[p]),
            .e_peer   (pipe_q.s1.en[p+N_PAIR]),
            .m_sum    (pipe_q.s1.mag[p]),
            .m_diff   (pipe_q.s1.mag[p+N_PAIR]),
            .thr      (pipe_q.s1.gam),
            .use_sum  (use_w[p]),
            .bit_sum  (bsum_w[p]),
            .bit_diff (bdiff_w[p])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        // stage 1: row energies and magnitudes
        pipe_d.s1.vld = in_valid;
        pipe_d.s1.gam = gamma;
        for (int l = 0; l < N_LANE; l++) begin
            pipe_d.s1.en[l]  = en_w[l];
            pipe_d.s1.mag[l] = mag_w[l];
        end
        // stage 2: branch choice and both threshold tests
        pipe_d.s2.vld     = pipe_q.s1.vld;
        pipe_d.s2.use_sum = use_w;
        pipe_d.s2.b_sum   = bsum_w;
        pipe_d.s2.b_diff  = bdiff_w;
        // stage 3: select, held between valid results
        pipe_d.s3.vld = pipe_q.s2.vld;
        if (pipe_q.s2.vld) begin
            for (int p = 0; p < N_PAIR; p++) begin
                pipe_d.s3.sym[p] = pipe_q.s2.use_sum[p] ? pipe_q.s2.b_sum[p]
                                                        : pipe_q.s2.b_diff[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s3.vld;
    assign sym       = pipe_q.s3.sym;
endmodule

// File: rtl/pnc_sel_decide_chk.sv
module pnc_sel_decide_chk
    import pnc_sel_pkg::*;
#(
    parameter int DW   = 12,
    parameter int GW   = 10,
    parameter int NCOL = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [N_LANE*DW-1:0]      det_y,
    input logic [N_LANE*NCOL*GW-1:0] g_re,
    input logic [N_LANE*NCOL*GW-1:0] g_im,
    input logic [DW-1:0]             gamma,
    input logic                      out_valid,
    input logic [N_PAIR-1:0]         sym
);
    logic [1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= 2'd0;
        else if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
    end

    function automatic longint row_pow(input logic [N_LANE*NCOL*GW-1:0] re,
                                       input logic [N_LANE*NCOL*GW-1:0] im,
                                       input int r);
        longint acc = 0;
        for (int c = 0; c < NCOL; c++) begin
            longint a = longint'($signed(re[(r*NCOL+c)*GW +: GW]));
            longint b = longint'($signed(im[(r*NCOL+c)*GW +: GW]));
            acc += a * a + b * b;
        end
        return acc;
    endfunction

    function automatic longint lane_abs(input logic [N_LANE*DW-1:0] y, input int j);
        longint v = longint'($signed(y[j*DW +: DW]));
        return (v < 0) ? -v : v;
    endfunction

    for (genvar p = 0; p < N_PAIR; p++) begin : g_chk
        // R3: quieter sum estimate decides
        p_sum_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == 2'd3 && out_valid &&
             row_pow($past(g_re,3), $past(g_im,3), p) <
             row_pow($past(g_re,3), $past(g_im,3), p+N_PAIR))
            |-> sym[p] == ((lane_abs($past(det_y,3), p) >= longint'($past(gamma,3)))
                           ? SYM_PLUS : SYM_MINUS));
        // R4: otherwise the difference estimate decides
        p_diff_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == 2'd3 && out_valid &&
             row_pow($past(g_re,3), $past(g_im,3), p) >=
             row_pow($past(g_re,3), $past(g_im,3), p+N_PAIR))
            |-> sym[p] == ((longint'($past(gamma,3)) >= lane_abs($past(det_y,3), p+N_PAIR))
                           ? SYM_PLUS : SYM_MINUS));
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == 2'd0 |-> (!out_valid && sym == '0));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == 2'd3 |-> out_valid == $past(in_valid, 3));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != 2'd0 && !out_valid) |-> $stable(sym));
endmodule

bind pnc_sel_decide pnc_sel_decide_chk #(.DW(DW), .GW(GW), .NCOL(NCOL)) chk_i (.*);

// File: tb/pnc_sel_decide_tb_top.sv
module pnc_sel_decide_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 12;
    localparam int GW   = 10;
    localparam int NCOL = 4;
    localparam int NL   = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   in_valid;
    logic [NL*DW-1:0]       det_y;
    logic [NL*NCOL*GW-1:0]  g_re;
    logic [NL*NCOL*GW-1:0]  g_im;
    logic [DW-1:0]          gamma;
    logic                   out_valid;
    logic [1:0]             sym;

    pnc_sel_decide #(.DW(DW), .GW(GW), .NCOL(NCOL)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic       hv [4];
    logic [1:0] hs [4];
    string      ht [4];
    logic [1:0] last_sym = 2'b00;

    int yv [NL];
    int gr [NL*NCOL];
    int gi [NL*NCOL];
    int gam;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [1:0] ref_sym();
        logic [1:0] r;
        for (int p = 0; p < 2; p++) begin
            longint eo = 0, ep = 0, ms, md;
            for (int c = 0; c < NCOL; c++) begin
                eo += gr[p*NCOL+c]*gr[p*NCOL+c] + gi[p*NCOL+c]*gi[p*NCOL+c];
                ep += gr[(p+2)*NCOL+c]*gr[(p+2)*NCOL+c] + gi[(p+2)*NCOL+c]*gi[(p+2)*NCOL+c];
            end
            ms = (yv[p] < 0) ? -yv[p] : yv[p];
            md = (yv[p+2] < 0) ? -yv[p+2] : yv[p+2];
            if (eo < ep) r[p] = (ms >= gam) ? 1'b0 : 1'b1;
            else         r[p] = (gam >= md) ? 1'b0 : 1'b1;
        end
        return r;
    endfunction

    task automatic set_row(input int r, input int re, input int im);
        for (int c = 0; c < NCOL; c++) begin
            gr[r*NCOL+c] = re;
            gi[r*NCOL+c] = im;
        end
    endtask

    task automatic randomize_all();
        for (int j = 0; j < NL; j++) yv[j] = $signed(DW'($urandom));
        for (int k = 0; k < NL*NCOL; k++) begin
            gr[k] = $signed(GW'($urandom));
            gi[k] = $signed(GW'($urandom));
        end
        gam = int'($urandom % (1 << (DW-1)));
    endtask

    task automatic step(input logic v, input string tag);
        int idx;
        @(negedge clk);
        if (cyc >= 3) begin
            idx = (cyc - 3) % 4;
            chk({ht[idx], "/R6 valid"}, out_valid, hv[idx]);
            if (hv[idx]) begin
                chk(ht[idx], sym, hs[idx]);
                last_sym = hs[idx];
            end else begin
                chk("R7 hold", sym, last_sym);
            end
        end
        for (int j = 0; j < NL; j++) det_y[j*DW +: DW] = DW'(yv[j]);
        for (int k = 0; k < NL*NCOL; k++) begin
            g_re[k*GW +: GW] = GW'(gr[k]);
            g_im[k*GW +: GW] = GW'(gi[k]);
        end
        gamma    = DW'(gam);
        in_valid = v;
        idx      = cyc % 4;
        hv[idx]  = v;
        hs[idx]  = ref_sym();
        ht[idx]  = tag;
        cyc++;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst_n = 1'b0; in_valid = 1'b0; det_y = '0; g_re = '0; g_im = '0; gamma = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 sym in reset", sym, 0);
        rst_n = 1'b1;

        // R3 + R5: stream 1 sum branch, |sum| exactly gamma
        // R4 + R5: stream 2 tie -> difference branch, |diff| exactly gamma
        randomize_all();
        set_row(0, 1, 0); set_row(2, 3, 2); set_row(1, 5, 5); set_row(3, -5, 5);
        gam = 300; yv[0] = -300; yv[2] = 2000; yv[1] = 0; yv[3] = 300;
        step(1, "R3 R5 sum on threshold");

        // R4: tie, diff above gamma -> -1 although sum test would say +1
        set_row(0, 7, -7); set_row(2, 7, 7); set_row(1, 2, 0); set_row(3, 2, 0);
        gam = 100; yv[0] = 1500; yv[2] = -101; yv[1] = 1500; yv[3] = 101;
        step(1, "R4 tie uses diff");

        // R8: opposite branches per stream, crossed wiring flips both
        set_row(0, 1, 1); set_row(2, 9, 9); set_row(1, 9, 9); set_row(3, 1, 1);
        gam = 500; yv[0] = 10; yv[2] = 10; yv[1] = 1000; yv[3] = 1000;
        step(1, "R8 streams separate");

        // R9: most negative lane value
        set_row(0, 1, 0); set_row(2, 4, 0); set_row(1, 4, 0); set_row(3, 1, 0);
        gam = 2048; yv[0] = -2048; yv[2] = 0; yv[1] = 0; yv[3] = -2048;
        step(1, "R9 full-scale sum");
        gam = 2047;
        step(1, "R9 full-scale diff");

        // R10: full-scale row versus one element short
        set_row(0, -512, -512); set_row(2, -512, -512); gi[2*NCOL] = 0;
        set_row(1, -512, -512); set_row(3, -512, -512); gr[1*NCOL] = 0;
        gam = 400; yv[0] = 5; yv[2] = 5; yv[1] = 5; yv[3] = 5;
        step(1, "R10 wide energy");

        // R2 R3 R4 R6: back-to-back random vectors
        for (int n = 0; n < 300; n++) begin
            randomize_all();
            step(1, "R2 R3 R4 random burst");
        end
        // R6 R7: gapped random traffic, inputs keep moving while idle
        for (int n = 0; n < 300; n++) begin
            logic v;
            randomize_all();
            v = ($urandom % 3) == 0;
            step(v, "R6 R7 gapped");
        end
        for (int n = 0; n < 5; n++) begin
            randomize_all();
            step(0, "R7 drain");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule